// File: doc/BRIEF.md
# Configuration Header Clock-Ratio Detector

This block listens to a stream of 32-bit configuration image words on its way to the configuration port. It does not change or forward them. Two header words at fixed positions in the stream carry the information it needs. One shows whether the image is encrypted, and a later one shows whether it is compressed. The block combines these two flags with the selected configuration bus width (16 or 32 bits) to produce the 2-bit clock-to-data ratio code. Software or a sequencer then writes that code into bits [17:16] of the configuration control word.

A `clr` pulse prepares the block for a new image. Words are counted only in cycles where `in_valid` is high. As soon as the compression word has been taken, a one-cycle `res_valid` strobe is raised, and the ratio and both flags hold until the next `clr`. If the stream ends before that word arrives, the block raises a sticky `short_err` and produces no ratio.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, `ratio`, `enc_flag`, `cmp_flag`, `res_valid` and `short_err` are all 0, and the block is ready to count from word 0.
- R2: The word index starts at 0 with the first word taken after reset or `clr`. Only cycles with `in_valid` high advance it, so idle gaps between words do not shift it.
- R3: The image is encrypted when bits [3:2] of word 69 are not both zero.
- R4: The image is compressed when bit 1 of word 229 is zero.
- R5: The ratio code values are 0 = x1, 1 = x2, 2 = x4 and 3 = x8. If the image is neither encrypted nor compressed, the code is 0 for either width.
- R6: A compressed image gives code 2 at width 16 (`wide_sel` = 0) and code 3 at width 32 (`wide_sel` = 1), whether or not it is encrypted.
- R7: An image that is encrypted but not compressed gives code 1 at width 16 and code 2 at width 32.
- R8: `res_valid` is high for exactly one cycle, the cycle after word 229 is taken. `ratio`, `enc_flag` and `cmp_flag` change only at that point or on `clr`.
- R9: If `in_last` is high (with or without `in_valid`) before word 229 has been taken, `short_err` rises in the next cycle and stays high until `clr`. `res_valid` never fires for that image, and `ratio` and both flags stay 0. This applies both before and after word 69.
- R10: If `in_last` arrives together with word 229, the result is valid and no error is raised. Any words or `in_last` that arrive after the result are ignored.
- R11: `clr` returns every output to 0 in the next cycle. A word presented in the same cycle as `clr` is not counted.
- R12: `wide_sel` is sampled only in the cycle word 229 is taken. Changing it at any other time has no effect on `ratio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Start/clear pulse for a new image |
| in_valid | input | 1 | A configuration word is present on `in_data` |
| in_data | input | 32 | Configuration word |
| in_last | input | 1 | End of the image stream |
| wide_sel | input | 1 | Bus width: 1 = 32-bit, 0 = 16-bit |
| ratio | output | 2 | Clock-to-data ratio code |
| enc_flag | output | 1 | Image is encrypted |
| cmp_flag | output | 1 | Image is compressed |
| res_valid | output | 1 | One-cycle strobe when the result is ready |
| short_err | output | 1 | Stream ended before the header was complete |

## Verification
All words other than the two header words are filled with a value that reads as both encrypted and compressed. An index that is off by one, or that advances during idle gaps or in a `clr` cycle, would therefore flip a flag or move the result strobe. The `wide_sel` input is held at its opposite value on every word except word 229, so a design that samples the width at the wrong time would return the wrong code. The end-of-stream tests cover an early end, a late-but-still-short end, an end signalled without a valid word, and an end on word 229 itself. A design that mixes up these cases would either raise an error on a complete header or report a ratio for a truncated one.

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect #(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1,
  localparam int IDX_W  = $clog2(CMP_IDX + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              wide_sel,
  output logic [1:0]        ratio,
  output logic              enc_flag,
  output logic              cmp_flag,
  output logic              res_valid,
  output logic              short_err
);

  logic [IDX_W-1:0] idx;
  logic             enc_hit;
  logic             busy;

  wire take    = in_valid && busy && !clr;
  wire at_enc  = take && (idx == IDX_W'(ENC_IDX));
  wire at_cmp  = take && (idx == IDX_W'(CMP_IDX));
  wire cut     = busy && !clr && in_last && !at_cmp;
  wire new_cmp = ~in_data[CMP_BIT];
  wire new_enc = |in_data[ENC_LSB+1:ENC_LSB];

  logic [1:0] new_ratio;
  always_comb begin
    if (!enc_hit && !new_cmp) new_ratio = 2'd0;
    else new_ratio = (new_cmp ? 2'd2 : 2'd1) + {1'b0, wide_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      enc_hit   <= 1'b0;
      busy      <= 1'b1;
      ratio     <= 2'd0;
      enc_flag  <= 1'b0;
      cmp_flag  <= 1'b0;
      res_valid <= 1'b0;
      short_err <= 1'b0;
    end else if (clr) begin
      idx       <= '0;
      enc_hit   <= 1'b0;
      busy      <= 1'b1;
      ratio     <= 2'd0;
      enc_flag  <= 1'b0;
      cmp_flag  <= 1'b0;
      res_valid <= 1'b0;
      short_err <= 1'b0;
    end else begin
      res_valid <= at_cmp;
      if (take) idx <= idx + 1'b1;
      if (at_enc) enc_hit <= new_enc;
      if (at_cmp) begin
        busy     <= 1'b0;
        ratio    <= new_ratio;
        enc_flag <= enc_hit;
        cmp_flag <= new_cmp;
      end
      if (cut) begin
        busy      <= 1'b0;
        short_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hdr_ratio_detect_chk.sv
module hdr_ratio_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic [1:0] ratio,
  input logic       enc_flag,
  input logic       cmp_flag,
  input logic       res_valid,
  input logic       short_err
);

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !$past(clr)) |-> ($stable(ratio) && $stable(enc_flag) && $stable(cmp_flag))); // R8

  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && short_err)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (short_err && !clr) |=> short_err); // R9

  AST_PLAIN_X1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !enc_flag && !cmp_flag) |-> (ratio == 2'd0)); // R5

  AST_CMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cmp_flag) |-> (ratio >= 2'd2)); // R6

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!res_valid && !short_err && ratio == 2'd0 && !enc_flag && !cmp_flag)); // R11

endmodule

bind hdr_ratio_detect hdr_ratio_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ratio(ratio), .enc_flag(enc_flag),
  .cmp_flag(cmp_flag), .res_valid(res_valid), .short_err(short_err)
);

// File: tb/hdr_ratio_detect_test.sv
module hdr_ratio_detect_test;

  localparam logic [31:0] FILL = 32'hFFFF_FFFD;

  // {w69, w229, wide, ratio, enc, cmp}
  localparam logic [68:0] VEC [8] = '{
    {32'hFFFF_FFF3, 32'h0000_0002, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'hFFFF_FFF3, 32'h0000_0002, 1'b1, 2'd0, 1'b0, 1'b0},
    {32'hFFFF_FFF3, 32'h0000_0000, 1'b0, 2'd2, 1'b0, 1'b1},
    {32'hFFFF_FFF3, 32'hFFFF_FFFD, 1'b1, 2'd3, 1'b0, 1'b1},
    {32'h0000_0004, 32'h0000_0002, 1'b0, 2'd1, 1'b1, 1'b0},
    {32'h0000_0008, 32'h0000_0002, 1'b1, 2'd2, 1'b1, 1'b0},
    {32'h0000_000C, 32'h0000_0000, 1'b0, 2'd2, 1'b1, 1'b1},
    {32'h0000_0004, 32'hFFFF_FFFD, 1'b1, 2'd3, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        wide_sel = 1'b0;
  logic [1:0]  ratio;
  logic        enc_flag, cmp_flag, res_valid, short_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hdr_ratio_detect uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .wide_sel(wide_sel), .ratio(ratio), .enc_flag(enc_flag),
    .cmp_flag(cmp_flag), .res_valid(res_valid), .short_err(short_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run_img(input logic [31:0] w69, input logic [31:0] w229, input logic wide,
                         input bit gaps, input bit flip, input int nwords, input int last_idx);
    for (int i = 0; i < nwords; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (i == 69) ? w69 : (i == 229) ? w229 : FILL;
      in_last  = (i == last_idx);
      wide_sel = (flip && i != 229) ? ~wide : wide;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; wide_sel = wide;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ratio", ratio, 0);
    check("R1 res_valid", res_valid, 0);
    check("R1 short_err", short_err, 0);
    check("R1 flags", {enc_flag, cmp_flag}, 0);
    rst_n = 1'b1;

    // R2 R8: first image straight after reset, no clr
    run_img(32'hFFFF_FFF3, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 230, -1);
    check("R2 after reset res_valid", res_valid, 1);
    check("R2 after reset ratio", ratio, 3);

    for (int v = 0; v < 8; v++) begin
      do_clr();
      check("R11 cleared ratio", ratio, 0);
      run_img(VEC[v][68:37], VEC[v][36:5], VEC[v][4], v[0], !v[0], 230, -1);
      check("R8 res_valid pulse", res_valid, 1);
      check("R5 R6 R7 ratio", ratio, int'(VEC[v][3:2]));
      check("R3 enc_flag", enc_flag, VEC[v][1]);
      check("R4 cmp_flag", cmp_flag, VEC[v][0]);
      check("R2 no error", short_err, 0);
      @(negedge clk);
      check("R8 pulse ends", res_valid, 0);
      check("R8 ratio held", ratio, int'(VEC[v][3:2]));
    end

    // R12: width change after result
    wide_sel = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 ratio ignores late width", ratio, 3);

    // R9: end before word 69
    do_clr();
    run_img(32'h0000_0004, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 41, 40);
    check("R9 early end err", short_err, 1);
    check("R9 early end no result", res_valid, 0);
    repeat (5) @(negedge clk);
    check("R9 err sticky", short_err, 1);
    check("R9 ratio zero", ratio, 0);

    // R9: end between 69 and 229
    do_clr();
    check("R11 err cleared", short_err, 0);
    run_img(32'h0000_0004, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 151, 150);
    check("R9 mid end err", short_err, 1);
    check("R9 mid end enc_flag", enc_flag, 0);
    check("R9 mid end ratio", ratio, 0);

    // R9: end marker without a valid word
    do_clr();
    run_img(32'hFFFF_FFF3, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 100, -1);
    @(negedge clk); in_last = 1'b1;
    @(negedge clk); in_last = 1'b0;
    check("R9 bare end err", short_err, 1);

    // R10: end on word 229, then extra words ignored
    do_clr();
    run_img(32'h0000_0008, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 230, 229);
    check("R10 end on last header word res", res_valid, 1);
    check("R10 end on last header word err", short_err, 0);
    check("R10 ratio", ratio, 1);
    @(negedge clk); in_valid = 1'b1; in_data = 32'h0; in_last = 1'b1;
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    check("R10 trailing end ignored", short_err, 0);
    check("R10 trailing word ratio", ratio, 1);
    check("R10 no second pulse", res_valid, 0);

    // R11: word in clr cycle not counted
    @(negedge clk); clr = 1'b1; in_valid = 1'b1; in_data = FILL;
    @(negedge clk); clr = 1'b0; in_valid = 1'b0;
    check("R11 clr outputs zero", {res_valid, short_err, enc_flag, cmp_flag}, 0);
    run_img(32'hFFFF_FFF3, 32'h0000_0002, 1'b1, 1'b0, 1'b0, 230, -1);
    check("R11 clr word skipped res", res_valid, 1);
    check("R11 clr word skipped ratio", ratio, 0);
    check("R11 clr word skipped enc", enc_flag, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule